// File: doc/BRIEF.md
# UART Baud Clock Generator

This block makes the sampling strobe for one serial channel: a single system-clock-wide pulse that occurs sixteen times per bit period. The strobe comes from one of two places. The first is a chain of two counters: a prescaler with four fixed ratios, followed by a programmable 8-bit integer divider. The second is an external baud reference clock. That reference is brought into the system clock domain and reduced to one pulse per rising edge, and in this mode the counters have no effect on the output.

Software picks the source with a 3-bit select, the prescaler ratio with a 2-bit select and the divider with an 8-bit value. Settings for the counter chain are captured only when a full output period ends. A change made in the middle of a period therefore never shortens or stretches that period. Take a 14.7456 MHz system clock as an example: ratio 2 with divide 48 gives a strobe at 153.6 kHz, which is 16 × 9600 bit/s, and ratio 2 with divide 1 gives 16 × 460800 bit/s.

Top module: `uart_baud_gen`

## Requirements
- R1: `pre_sel` picks the prescaler ratio as 2^(2·pre_sel+1): code 0 divides by 2, 1 by 8, 2 by 32 and 3 by 128.
- R2: With `src_sel` not equal to 3'b100 and a divide value D from 1 to 255, `baud_tick` pulses once every R·D system clock cycles, where R is the prescaler ratio.
- R3: A divide value of 0 acts as 256, so the period becomes R·256 cycles.
- R4: With `src_sel` equal to 3'b100, `baud_tick` pulses once for each rising edge of `ext_clk`, on the third rising system clock edge after the change. `pre_sel` and `div_val` have no effect on the output in this mode.
- R5: Every `src_sel` code other than 3'b100 (for example 3'b000 or 3'b111) selects the prescaler and divider chain.
- R6: When `pre_sel` or `div_val` changes, the period already under way finishes with the old settings. The new settings take effect from the next period.
- R7: Every `baud_tick` pulse lasts exactly one system clock cycle.
- R8: While `rst_n` is low, `baud_tick` stays low and both counters are cleared. The first pulse after reset arrives on rising edge R·D counted from the first edge at which `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 3 | Clock source select; 3'b100 selects the external reference |
| pre_sel | input | 2 | Prescaler ratio select (2, 8, 32, 128) |
| div_val | input | 8 | Integer divide value; 0 means 256 |
| ext_clk | input | 1 | External baud reference clock, asynchronous |
| baud_tick | output | 1 | One-cycle strobe at 16 times the bit rate |

## Verification
For the counter chain, the first pulse is due R·D rising edges after reset is released. Each later pulse is due R·D edges after the one before it. After a settings change, the next pulse still uses the old spacing and only the pulse after that uses the new one. For the external path, a pulse is due three edges after `ext_clk` rises: two synchroniser flops plus the output register. The bench drives inputs on falling edges and counts falling edges between pulses, so each expected count equals the number of register stages and counter steps exactly.

// File: rtl/baud_pkg.sv
// Package: shared constants for the baud clock generator.
// Assumes: prescaler ratios are odd powers of two, 2^(2k+1).
package baud_pkg;
    localparam int          PRE_STEPS   = 4;                 // number of prescaler ratios
    localparam int          PRE_SEL_W   = $clog2(PRE_STEPS); // width of the ratio select
    localparam int          PRE_W       = 2 * PRE_STEPS - 1; // prescaler counter width
    localparam int          SRC_W       = 3;                 // source select width
    localparam logic [2:0]  SRC_BYPASS  = 3'b100;            // external reference code
endpackage

// File: rtl/baud_prescaler.sv
// Module: baud_prescaler
// Counts system clocks and pulses pre_tick once per 2^(2*sel+1) cycles.
// Assumes: the active ratio is captured only when reload is high, which the
// divider asserts at the end of a full output period.
module baud_prescaler
    import baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PRE_SEL_W-1:0] sel_in,
    input  logic                 reload,
    output logic                 pre_tick
);
    logic [PRE_SEL_W-1:0] act_sel;
    logic [PRE_W-1:0]     pre_cnt;
    logic [PRE_W-1:0]     pre_last;

    // Terminal count of the active ratio.
    always_comb pre_last = PRE_W'((1 << (2 * int'(act_sel) + 1)) - 1);

    assign pre_tick = (pre_cnt == pre_last);

    // Capture the ratio at reset or at the end of an output period.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) act_sel <= sel_in;
    end

    // Free-running count that wraps at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || pre_tick) pre_cnt <= '0;
        else                    pre_cnt <= pre_cnt + 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_last);                                   // R1
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(act_sel));                          // R6
endmodule

// File: rtl/baud_divider.sv
// Module: baud_divider
// Counts prescaler pulses and flags the end of each group of D of them.
// Assumes: a divide value of 0 wraps through all 256 states.
module baud_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_in,
    input  logic             pre_tick,
    output logic             term
);
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;

    // 0 - 1 wraps to all ones, so 0 behaves as 2^DIV_W.
    always_comb div_last = act_div - 1'b1;

    assign term = pre_tick && (div_cnt == div_last);

    // Capture the divide value at reset or at the end of an output period.
    always_ff @(posedge clk) begin
        if (!rst_n || term) act_div <= div_in;
    end

    // Step once per prescaler pulse; clear at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || term) div_cnt <= '0;
        else if (pre_tick)  div_cnt <= div_cnt + 1'b1;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div != '0) |-> (div_cnt < act_div));               // R2
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(act_div));                            // R6
endmodule

// File: rtl/baud_ext_sync.sv
// Module: baud_ext_sync
// Brings an asynchronous reference clock into the system domain through two
// flops and gives a one-cycle pulse on each rising edge.
// Assumes: the reference is slower than half the system clock.
module baud_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic [2:0] sync_q;

    // Shift the reference through the synchroniser and the edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_in};
    end

    assign rise = sync_q[1] && !sync_q[2];

    AST_EXT_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);                                        // R4
endmodule

// File: rtl/uart_baud_gen.sv
// Module: uart_baud_gen (top)
// Chooses between the prescaler/divider chain and the synchronised external
// reference, and registers the chosen strobe onto baud_tick.
// Assumes: src_sel is quasi-static; the counter chain keeps running while
// bypassed so that a return to it needs no restart.
module uart_baud_gen
    import baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_W-1:0]     src_sel,
    input  logic [PRE_SEL_W-1:0] pre_sel,
    input  logic [DIV_W-1:0]     div_val,
    input  logic                 ext_clk,
    output logic                 baud_tick
);
    logic pre_tick;
    logic gen_tick;
    logic ext_rise;
    logic bypass;

    assign bypass = (src_sel == SRC_BYPASS);

    baud_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_in   (pre_sel),
        .reload   (gen_tick),
        .pre_tick (pre_tick)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_in   (div_val),
        .pre_tick (pre_tick),
        .term     (gen_tick)
    );

    baud_ext_sync u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_clk),
        .rise   (ext_rise)
    );

    // Register the selected strobe onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n)      baud_tick <= 1'b0;
        else if (bypass) baud_tick <= ext_rise;
        else             baud_tick <= gen_tick;
    end

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);                              // R7
    AST_BYPASS_NO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !ext_rise) |=> !baud_tick);                  // R4
    AST_CHAIN_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !gen_tick) |=> !baud_tick);                 // R5
endmodule

// File: tb/uart_baud_gen_test.sv
// Directed bench for uart_baud_gen: one task per scenario.
module uart_baud_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel = 3'b000;
    logic [1:0] pre_sel = 2'd0;
    logic [7:0] div_val = 8'd1;
    logic       ext_clk = 1'b0;
    logic       baud_tick;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    uart_baud_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .pre_sel   (pre_sel),
        .div_val   (div_val),
        .ext_clk   (ext_clk),
        .baud_tick (baud_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks = n_checks + 1;
        if (got != exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Count falling edges until baud_tick is seen high (-1 on timeout).
    task automatic wait_tick(output int n, input int limit);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (baud_tick) begin
                n = i;
                return;
            end
        end
        n = -1;
    endtask

    // Reset with the given settings, released at a falling edge.
    task automatic do_reset(input logic [2:0] s, input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        rst_n = 1'b0; src_sel = s; pre_sel = p; div_val = d; ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int ratio(input logic [1:0] p);
        return 2 << (2 * int'(p));
    endfunction

    // First-pulse latency and two periods for one setting.
    task automatic run_chain(input string tag, input logic [2:0] s, input logic [1:0] p,
                             input logic [7:0] d);
        int n;
        int exp;
        exp = ratio(p) * ((d == 0) ? 256 : int'(d));
        do_reset(s, p, d);
        wait_tick(n, exp + 8);
        check({tag, " first pulse"}, n, exp);
        wait_tick(n, exp + 8);
        check({tag, " period"}, n, exp);
        wait_tick(n, exp + 8);
        check({tag, " period again"}, n, exp);
    endtask

    task automatic test_reset_r8();
        int seen;
        seen = 0;
        @(negedge clk);
        rst_n = 1'b0; src_sel = 3'b000; pre_sel = 2'd0; div_val = 8'd1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (baud_tick) seen++;
        end
        check("R8 no pulse in reset", seen, 0);
        run_chain("R8 after reset", 3'b000, 2'd1, 8'd2);
    endtask

    task automatic test_ratios_r1();
        for (int p = 0; p < 4; p++)
            run_chain("R1 ratio", 3'b000, 2'(p), 8'd3);
    endtask

    task automatic test_divide_r2();
        run_chain("R2 div 48 (9600 baud)", 3'b001, 2'd0, 8'd48);
        run_chain("R2 div 1 (460800 baud)", 3'b000, 2'd0, 8'd1);
        run_chain("R2 div 255", 3'b000, 2'd0, 8'd255);
        run_chain("R2 ratio 32 div 7", 3'b010, 2'd2, 8'd7);
    endtask

    task automatic test_zero_r3();
        run_chain("R3 div 0 ratio 2", 3'b000, 2'd0, 8'd0);
        run_chain("R3 div 0 ratio 8", 3'b000, 2'd1, 8'd0);
    endtask

    task automatic test_codes_r5();
        run_chain("R5 code 111", 3'b111, 2'd1, 8'd5);
        run_chain("R5 code 011", 3'b011, 2'd0, 8'd9);
        run_chain("R5 code 101", 3'b101, 2'd0, 8'd3);
    endtask

    task automatic test_change_r6();
        int n;
        run_chain("R6 base", 3'b000, 2'd0, 8'd4);
        div_val = 8'd10;                       // changed just after a pulse
        wait_tick(n, 40);
        check("R6 old divide completes", n, 8);
        wait_tick(n, 40);
        check("R6 new divide applies", n, 20);
        pre_sel = 2'd1;                        // ratio 8, divide 10
        wait_tick(n, 200);
        check("R6 old ratio completes", n, 20);
        wait_tick(n, 200);
        check("R6 new ratio applies", n, 80);
    endtask

    task automatic test_width_r7();
        int highs;
        highs = 0;
        do_reset(3'b000, 2'd0, 8'd1);          // period 2: densest strobe
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_tick) highs++;
        end
        check("R7 one-cycle pulses at period 2", highs, 20);
    endtask

    task automatic test_bypass_r4();
        int where_seen;
        int count;
        do_reset(3'b100, 2'd0, 8'd1);          // chain alone would pulse every 2
        count = 0;
        repeat (4) @(negedge clk);
        for (int p = 0; p < 5; p++) begin
            where_seen = -1;
            if (p == 2) begin pre_sel = 2'd3; div_val = 8'd0; end
            for (int k = 0; k < 20; k++) begin
                ext_clk = (k < 10);
                @(negedge clk);
                if (baud_tick) begin
                    count++;
                    where_seen = k;
                end
            end
            check("R4 pulse on third edge after ext rise", where_seen, 2);
        end
        check("R4 one pulse per ext rise", count, 5);
    endtask

    initial begin
        test_reset_r8();
        test_ratios_r1();
        test_divide_r2();
        test_zero_r3();
        test_codes_r5();
        test_change_r6();
        test_width_r7();
        test_bypass_r4();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule